// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block is a memory-mapped pulse-width modulator with two independent channels. A simple single-cycle register bus reaches one shared control word and one period/duty word per channel. Each channel first divides the input clock by a fixed divisor. A 4-bit code picks the divisor from an irregular table, and one code skips the division entirely. The divided ticks then step a 16-bit period counter, and comparing that counter against a 16-bit duty count produces the output waveform. The output level is selectable, and the channel has separate enable and clock-gating controls.

A period/duty write goes into a shadow copy. The running channel takes the new value at its next period wrap, so a waveform never changes in the middle of a period. A ready bit per channel in the control word shows that a written value is still waiting to be taken up. Software sets up a channel by writing its period/duty word and then the control fields. It can retune a running channel at any time and poll the ready bit before writing again.

Top module: `pwm2ch_ctrl`

## Requirements
- R1: After reset, every register reads 0 and each output sits at its inactive level, which is 1 because the active-level bit resets to 0.
- R2: The control word is at byte address 0x0. Channel n keeps its fields at bit offset 15*n: prescaler code [3:0], enable bit 4, active-level bit 5, clock-gate bit 6, and two stored spare mode bits 7 and 8. All field bits read back as written. Every other bit reads 0, except the ready bits of R10, which ignore writes.
- R3: The period/duty word of channel n is at byte address 0x4+4*n. Bits [31:16] hold the period length minus one and bits [15:0] hold the duty count. A read returns the last value written. A write to any other address changes nothing.
- R4: Prescaler codes 0,1,2,3,4 give one counter step every 120, 180, 240, 360 and 480 clocks. Codes 8,9,10,11,12 give one step every 12000, 24000, 36000, 48000 and 72000 clocks. Code 15 steps the counter on every clock.
- R5: The period counter runs from 0 up to the period field and then wraps to 0. The output is at the active level while the counter is below the duty count. A duty of 0 never reaches the active level, and a duty above the period field stays active for the whole period.
- R6: An active-level bit of 1 makes the active level high. A bit of 0 makes it low. The inactive level is always the opposite of the active level.
- R7: While a channel's enable bit is 0, its output is inactive and its divider and period counter are held at 0. After the channel is enabled again, the waveform restarts from count 0.
- R8: While a channel is enabled with its clock-gate bit at 0, the output is inactive and the counters hold their values. Setting the gate again resumes counting from the held count.
- R9: The reserved codes 5, 6, 7, 13 and 14 stop the counters in place and hold the output at the inactive level.
- R10: A period/duty write sets the channel's ready bit (control bit 28+n) on the next cycle. The running channel takes the new value at the clock that wraps its counter, and the ready bit clears at that clock. A disabled channel takes the value on the next clock.
- R11: If a period/duty write lands on the same clock as a wrap, the wrap takes the value that was already pending. The new value stays pending, with the ready bit at 1, until the following wrap.
- R12: Writes to one channel's fields or period/duty word have no effect on the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers, dividers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier; a write happens at the edge where bus_sel and bus_we are both 1 |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
A period/duty write and a period wrap can fall on the same clock edge: the write fills the shadow copy while the wrap empties it. The bench provokes this with the channel running undivided at a known period. It places one write in the middle of a period and then times a second write to land exactly on the wrap edge, counting edges from the enable write. It judges the outcome by reading the ready bit straight after that edge and by checking the output pattern over the next two periods. The first of those periods must show the middle-of-period value and the second must show the colliding value.

// File: rtl/pwm2ch_pkg.sv
package pwm2ch_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int PSC_W     = 17;
    localparam int CODE_W    = 4;
    localparam int CH_STRIDE = 15;
    localparam int FIELD_W   = 9;
    localparam int RDY_BASE  = 28;

    localparam logic [CODE_W-1:0] CODE_BYPASS = 4'hF;

    // Field layout inside one channel slice of the control word
    typedef struct packed {
        logic              spare_b;
        logic              spare_a;
        logic              gate;
        logic              act;
        logic              en;
        logic [CODE_W-1:0] code;
    } ch_ctrl_t;

    // Clocks per counter step; 0 marks a reserved code
    function automatic logic [PSC_W-1:0] psc_div(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:        return 17'd120;
            4'd1:        return 17'd180;
            4'd2:        return 17'd240;
            4'd3:        return 17'd360;
            4'd4:        return 17'd480;
            4'd8:        return 17'd12000;
            4'd9:        return 17'd24000;
            4'd10:       return 17'd36000;
            4'd11:       return 17'd48000;
            4'd12:       return 17'd72000;
            CODE_BYPASS: return 17'd1;
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/pwm2ch_regs.sv
module pwm2ch_regs
    import pwm2ch_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic [NUM_CH-1:0]              load_i,
    output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
    output logic [NUM_CH-1:0]              en_o,
    output logic [NUM_CH-1:0]              gate_o,
    output logic [NUM_CH-1:0]              act_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]  shd_o,
    output logic [NUM_CH-1:0]              pend_o,
    output logic [DATA_W-1:0]              rdata_o
);

    typedef struct packed {
        ch_ctrl_t [NUM_CH-1:0]             ctrl;
        logic     [NUM_CH-1:0][DATA_W-1:0] shd;
        logic     [NUM_CH-1:0]             pend;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic wr_en;

    always_comb begin
        rf_d    = rf_q;
        wr_en   = bus_sel && bus_we;
        rdata_o = '0;

        for (int n = 0; n < NUM_CH; n++) begin
            // a wrap load clears the flag, a same-cycle write sets it again
            rf_d.pend[n] = rf_q.pend[n] && !load_i[n];
            if (wr_en && bus_addr == '0) begin
                rf_d.ctrl[n] = bus_wdata[n*CH_STRIDE +: FIELD_W];
            end
            if (wr_en && bus_addr == ADDR_W'(4 * (n + 1))) begin
                rf_d.shd[n]  = bus_wdata;
                rf_d.pend[n] = 1'b1;
            end

            if (bus_addr == '0) begin
                rdata_o[n*CH_STRIDE +: FIELD_W] = rf_q.ctrl[n];
                rdata_o[RDY_BASE + n]           = rf_q.pend[n];
            end
            if (bus_addr == ADDR_W'(4 * (n + 1))) begin
                rdata_o = rf_q.shd[n];
            end

            code_o[n] = rf_q.ctrl[n].code;
            en_o[n]   = rf_q.ctrl[n].en;
            gate_o[n] = rf_q.ctrl[n].gate;
            act_o[n]  = rf_q.ctrl[n].act;
            shd_o[n]  = rf_q.shd[n];
            pend_o[n] = rf_q.pend[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

endmodule

// File: rtl/pwm2ch_chan.sv
module pwm2ch_chan
    import pwm2ch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              en_i,
    input  logic              gate_i,
    input  logic              act_i,
    input  logic              pend_i,
    input  logic [DATA_W-1:0] shd_i,
    output logic              load_o,
    output logic              out_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  prd_o
);

    localparam logic [PSC_W-1:0] PSC_ONE = 1;

    typedef struct packed {
        logic [PSC_W-1:0] pc;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] dty;
    } ch_st_t;

    ch_st_t           st_d, st_q;
    logic [PSC_W-1:0] div;
    logic             run, tick, wrap;

    always_comb begin
        div    = psc_div(code_i);
        run    = en_i && gate_i && (div != '0);
        tick   = run && (st_q.pc == div - PSC_ONE);
        wrap   = tick && (st_q.cnt == st_q.prd);
        load_o = pend_i && (!en_i || wrap);

        st_d = st_q;
        if (!en_i) begin
            st_d.pc  = '0;
            st_d.cnt = '0;
        end else if (run) begin
            if (tick) begin
                st_d.pc  = '0;
                st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            end else begin
                st_d.pc = st_q.pc + 1'b1;
            end
        end
        if (load_o) begin
            st_d.prd = shd_i[DATA_W-1:CNT_W];
            st_d.dty = shd_i[CNT_W-1:0];
        end

        out_o = (run && (st_q.cnt < st_q.dty)) ? act_i : !act_i;
        cnt_o = st_q.cnt;
        prd_o = st_q.prd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm2ch_ctrl.sv
module pwm2ch_ctrl
    import pwm2ch_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0][CODE_W-1:0] code_v;
    logic [NUM_CH-1:0]             en_v, gate_v, act_v, pend_v, load_v, rsv_v;
    logic [NUM_CH-1:0][DATA_W-1:0] shd_v;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_v, prd_v;

    pwm2ch_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .load_i    (load_v),
        .code_o    (code_v),
        .en_o      (en_v),
        .gate_o    (gate_v),
        .act_o     (act_v),
        .shd_o     (shd_v),
        .pend_o    (pend_v),
        .rdata_o   (bus_rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm2ch_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .code_i (code_v[n]),
            .en_i   (en_v[n]),
            .gate_i (gate_v[n]),
            .act_i  (act_v[n]),
            .pend_i (pend_v[n]),
            .shd_i  (shd_v[n]),
            .load_o (load_v[n]),
            .out_o  (pwm_out[n]),
            .cnt_o  (cnt_v[n]),
            .prd_o  (prd_v[n])
        );
        assign rsv_v[n] = (psc_div(code_v[n]) == '0);
    end

endmodule

// File: rtl/pwm2ch_ctrl_chk.sv
module pwm2ch_ctrl_chk
    import pwm2ch_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_CH-1:0]              en_v,
    input logic [NUM_CH-1:0]              gate_v,
    input logic [NUM_CH-1:0]              rsv_v,
    input logic [NUM_CH-1:0]              pend_v,
    input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_v,
    input logic [NUM_CH-1:0][CNT_W-1:0]   prd_v
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_v[n] <= prd_v[n]); // R5
        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cnt_v[n]) |-> (cnt_v[n] == '0 || cnt_v[n] == $past(cnt_v[n]) + 16'd1)); // R5
        AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !en_v[n] |=> cnt_v[n] == '0); // R7
        AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[n] && !gate_v[n]) |=> $stable(cnt_v[n])); // R8
        AST_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[n] && rsv_v[n]) |=> $stable(cnt_v[n])); // R9
        AST_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_v[n]) |-> cnt_v[n] == '0); // R10
    end

endmodule

bind pwm2ch_ctrl pwm2ch_ctrl_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_v   (en_v),
    .gate_v (gate_v),
    .rsv_v  (rsv_v),
    .pend_v (pend_v),
    .cnt_v  (cnt_v),
    .prd_v  (prd_v)
);

// File: tb/pwm2ch_ctrl_bench.sv
module pwm2ch_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm2ch_ctrl u_pwm2ch_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // write lands on the second rising edge after the call; returns just after it
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl(input int ch, input logic [3:0] code,
                                        input logic en, input logic act, input logic gate);
        logic [31:0] f;
        f = {23'd0, 2'b00, gate, act, en, code};
        return f << (15 * ch);
    endfunction

    function automatic logic [31:0] pd(input int prd, input int dty);
        return {prd[15:0], dty[15:0]};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got expired expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int divs[6];
        int codes[6];
        int rsv[5];
        divs  = '{120, 180, 240, 360, 480, 12000};
        codes = '{0, 1, 2, 3, 4, 8};
        rsv   = '{5, 6, 7, 13, 14};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        bus_read(4'h0, rd); chk("R1 ctrl", rd, 32'h0);
        bus_read(4'h4, rd); chk("R1 pd0", rd, 32'h0);
        bus_read(4'h8, rd); chk("R1 pd1", rd, 32'h0);
        chk("R1 outputs", 32'(pwm_out), 32'h3);

        // R2 control readback mask, ready bits read-only
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, rd);
        chk("R2 readback", rd, 32'h1FF | (32'h1FF << 15));
        bus_write(4'h0, 32'h0);
        // R3 readback and unmapped write
        bus_write(4'h4, 32'h1234_5678);
        bus_write(4'h8, 32'h9ABC_DEF0);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'h4, rd); chk("R3 pd0", rd, 32'h1234_5678);
        bus_read(4'h8, rd); chk("R3 pd1", rd, 32'h9ABC_DEF0);
        bus_read(4'h0, rd); chk("R3 unmapped", rd, 32'h0);

        // R5 R6 R12 sweep on channel 1 with the divider bypassed
        for (int a = 0; a < 2; a++) begin
            for (int p = 0; p < 6; p++) begin
                for (int d = 0; d < 8; d++) begin
                    bus_write(4'h8, pd(p, d));
                    bus_read(4'h0, rd);
                    chk("R10 ready set ch1", 32'(rd[29]), 32'h1);
                    bus_write(4'h0, ctl(1, 4'hF, 1'b1, a[0], 1'b1));
                    bus_read(4'h0, rd);
                    chk("R10 loaded while disabled", 32'(rd[29]), 32'h0);
                    for (int k = 0; k < 2 * (p + 1); k++) begin
                        chk("R5 R6 waveform", 32'(pwm_out[1]),
                            32'(((k % (p + 1)) < d) ? a[0] : !a[0]));
                        chk("R12 ch0 untouched", 32'(pwm_out[0]), 32'h1);
                        step();
                    end
                    bus_write(4'h0, 32'h0);
                    chk("R7 disabled inactive", 32'(pwm_out[1]), 32'h1);
                end
            end
        end

        // R7 disable mid-period restarts from zero
        bus_write(4'h4, pd(5, 3));
        bus_write(4'h0, ctl(0, 4'hF, 1'b1, 1'b1, 1'b1));
        step(); step();
        bus_write(4'h0, ctl(0, 4'hF, 1'b0, 1'b1, 1'b1));
        for (int k = 0; k < 3; k++) begin
            chk("R7 off", 32'(pwm_out[0]), 32'h0);
            step();
        end
        bus_write(4'h0, ctl(0, 4'hF, 1'b1, 1'b1, 1'b1));
        for (int k = 0; k < 6; k++) begin
            chk("R7 restart", 32'(pwm_out[0]), 32'((k < 3) ? 1 : 0));
            step();
        end
        bus_write(4'h0, 32'h0);

        // R8 gate clear freezes at count 2, resumes from it
        bus_write(4'h4, pd(7, 4));
        bus_write(4'h0, ctl(0, 4'hF, 1'b1, 1'b1, 1'b1));
        bus_write(4'h0, ctl(0, 4'hF, 1'b1, 1'b1, 1'b0));
        for (int k = 0; k < 4; k++) begin
            chk("R8 gated off", 32'(pwm_out[0]), 32'h0);
            step();
        end
        bus_write(4'h0, ctl(0, 4'hF, 1'b1, 1'b1, 1'b1));
        chk("R8 resume c2", 32'(pwm_out[0]), 32'h1);
        step();
        chk("R8 resume c3", 32'(pwm_out[0]), 32'h1);
        step();
        chk("R8 resume c4", 32'(pwm_out[0]), 32'h0);
        bus_write(4'h0, 32'h0);

        // R9 reserved codes stop the counter
        bus_write(4'h4, pd(7, 1));
        foreach (rsv[i]) begin
            bus_write(4'h0, 32'h0);
            bus_write(4'h0, ctl(0, 4'(rsv[i]), 1'b1, 1'b1, 1'b1));
            for (int k = 0; k < 20; k++) begin
                chk("R9 reserved inactive", 32'(pwm_out[0]), 32'h0);
                step();
            end
            bus_write(4'h0, ctl(0, 4'hF, 1'b1, 1'b1, 1'b1));
            chk("R9 count held at 0", 32'(pwm_out[0]), 32'h1);
            step();
            chk("R9 then count 1", 32'(pwm_out[0]), 32'h0);
        end
        bus_write(4'h0, 32'h0);

        // R4 divisor table
        bus_write(4'h4, pd(1, 1));
        foreach (codes[i]) begin
            int hi;
            int lo;
            bus_write(4'h0, 32'h0);
            bus_write(4'h0, ctl(0, 4'(codes[i]), 1'b1, 1'b1, 1'b1));
            hi = 0;
            while (pwm_out[0] == 1'b1 && hi < divs[i] + 5) begin hi++; step(); end
            lo = 0;
            while (pwm_out[0] == 1'b0 && lo < divs[i] + 5) begin lo++; step(); end
            chk("R4 high ticks", 32'(hi), 32'(divs[i]));
            chk("R4 low ticks", 32'(lo), 32'(divs[i]));
        end
        bus_write(4'h0, 32'h0);

        // R10 R11 shadow load and write colliding with the wrap
        bus_write(4'h4, pd(3, 2));
        bus_write(4'h0, ctl(0, 4'hF, 1'b1, 1'b1, 1'b1));
        bus_write(4'h4, pd(4, 3));
        bus_read(4'h0, rd);
        chk("R10 ready after write", 32'(rd[28]), 32'h1);
        bus_write(4'h4, pd(2, 1));
        bus_read(4'h0, rd);
        chk("R11 still pending", 32'(rd[28]), 32'h1);
        for (int k = 0; k < 5; k++) begin
            chk("R11 middle value active", 32'(pwm_out[0]), 32'((k < 3) ? 1 : 0));
            step();
        end
        bus_read(4'h0, rd);
        chk("R10 ready cleared at wrap", 32'(rd[28]), 32'h0);
        for (int k = 0; k < 4; k++) begin
            chk("R11 colliding value active", 32'(pwm_out[0]), 32'(((k % 3) < 1) ? 1 : 0));
            step();
        end
        bus_write(4'h0, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule